// File: doc/BRIEF.md
# Bouncing Box Position Updater

This block moves a square box across a rectangular screen by one pixel per axis on every frame. When the box reaches an edge it turns back. The default screen is 640 by 480 pixels and the default box is 32 by 32. The position is the box's upper-left corner. Each axis has its own velocity of +1 or -1. Velocities are held as plain unsigned vectors in two's complement, at the full width of their position, so -1 is all ones. Each axis turns at its own limits, independently of the other: 0 and 608 for x, 0 and 448 for y.

The core is a combinational next-state function of the current corner, the two velocities and a halt input. A small register stage sits around it. That stage takes the next values when a one-cycle frame tick arrives, and a synchronous reset returns it to its start state. Both the current state and the combinational next values are visible at the ports. Drawing, video timing and the source of the frame tick are outside the block.

Top module: `bbox_mover`

## Requirements
- R1: When rst is high at a rising clock edge, the state becomes pos_x = 0, pos_y = 0, vel_x = 10'h001 and vel_y = 9'h001.
- R2: At an edge with frame_tick low, the position and velocity outputs keep their values.
- R3: Away from a bouncing condition, the next position of an axis is its position plus one when the velocity MSB is 0, and minus one when the MSB is 1. The velocity is unchanged, and the state takes these values at an edge with frame_tick high.
- R4: An axis at or beyond its upper limit (x 608, y 448) with velocity MSB 0 gets next position limit-1 and next velocity all ones (10'h3FF for x, 9'h1FF for y).
- R5: An axis at position 0 with velocity MSB 1 gets next position 1 and next velocity +1 (value 1).
- R6: The x and y axes are updated independently, so one axis reverses while the other keeps stepping.
- R7: With halt high, the next outputs equal the current state, and a frame tick changes nothing.
- R8: Starting from reset, pos_x never exceeds 608 and pos_y never exceeds 448.
- R9: The registered velocities only ever hold +1 or all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse that loads the next state |
| halt | input | 1 | Freeze position and velocity |
| pos_x | output | 10 | Current box corner x |
| pos_y | output | 9 | Current box corner y |
| vel_x | output | 10 | Current x velocity, two's complement +1 or -1 |
| vel_y | output | 9 | Current y velocity, two's complement +1 or -1 |
| nxt_pos_x | output | 10 | Combinational next corner x |
| nxt_pos_y | output | 9 | Combinational next corner y |
| nxt_vel_x | output | 10 | Combinational next x velocity |
| nxt_vel_y | output | 9 | Combinational next y velocity |

## Verification
The bounds and velocity-value properties assume that the state is only ever reached from reset through the block's own updates. No port allows an arbitrary corner to be loaded, so the stimulus cannot break this. The bench controls only reset, frame_tick and halt. It sweeps several thousand frames so that each axis completes more than one full trip between its limits. Tick-free cycles and halt windows are mixed in, and every cycle is compared against an arithmetic model of the trajectory.

// File: rtl/bbox_pkg.sv
package bbox_pkg;

    // Default screen geometry in pixels
    localparam int SCREEN_W = 640;
    localparam int SCREEN_H = 480;
    localparam int BOX_SIDE = 32;

    // Per-axis update kind
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_STEP    = 2'd1,
        ACT_TURN_HI = 2'd2,
        ACT_TURN_LO = 2'd3
    } axis_act_e;

    // Pick the update kind for one axis
    function automatic axis_act_e pick_act(input logic halt,
                                           input logic neg,
                                           input logic at_hi,
                                           input logic at_lo);
        axis_act_e a;
        if (halt)
            a = ACT_HOLD;
        else if (!neg && at_hi)
            a = ACT_TURN_HI;
        else if (neg && at_lo)
            a = ACT_TURN_LO;
        else
            a = ACT_STEP;
        return a;
    endfunction

endpackage

// File: rtl/bbox_axis.sv
module bbox_axis
    import bbox_pkg::*;
#(
    parameter int W  = 10,
    parameter int HI = 608
) (
    input  logic         halt,
    input  logic [W-1:0] pos,
    input  logic [W-1:0] vel,
    output logic [W-1:0] nxt_pos,
    output logic [W-1:0] nxt_vel
);

    localparam logic [W-1:0] ONE   = W'(1);
    localparam logic [W-1:0] MINUS = {W{1'b1}};
    localparam logic [W-1:0] LIMIT = W'(HI);

    logic      neg;
    logic      at_hi;
    logic      at_lo;
    axis_act_e act;

    assign neg   = vel[W-1];
    assign at_hi = (pos >= LIMIT);
    assign at_lo = (pos == '0);
    assign act   = pick_act(halt, neg, at_hi, at_lo);

    always_comb begin
        nxt_pos = pos;
        nxt_vel = vel;
        unique case (act)
            ACT_HOLD: begin
                nxt_pos = pos;
                nxt_vel = vel;
            end
            ACT_TURN_HI: begin
                nxt_pos = LIMIT - ONE;
                nxt_vel = MINUS;
            end
            ACT_TURN_LO: begin
                nxt_pos = ONE;
                nxt_vel = ONE;
            end
            default: begin
                nxt_pos = pos + (neg ? MINUS : ONE);
                nxt_vel = neg ? MINUS : ONE;
            end
        endcase
    end

endmodule

// File: rtl/bbox_next.sv
module bbox_next #(
    parameter int XW  = 10,
    parameter int YW  = 9,
    parameter int XHI = 608,
    parameter int YHI = 448
) (
    input  logic          halt,
    input  logic [XW-1:0] pos_x,
    input  logic [YW-1:0] pos_y,
    input  logic [XW-1:0] vel_x,
    input  logic [YW-1:0] vel_y,
    output logic [XW-1:0] nxt_pos_x,
    output logic [YW-1:0] nxt_pos_y,
    output logic [XW-1:0] nxt_vel_x,
    output logic [YW-1:0] nxt_vel_y
);

    bbox_axis #(.W(XW), .HI(XHI)) u_ax_x (
        .halt    (halt),
        .pos     (pos_x),
        .vel     (vel_x),
        .nxt_pos (nxt_pos_x),
        .nxt_vel (nxt_vel_x)
    );

    bbox_axis #(.W(YW), .HI(YHI)) u_ax_y (
        .halt    (halt),
        .pos     (pos_y),
        .vel     (vel_y),
        .nxt_pos (nxt_pos_y),
        .nxt_vel (nxt_vel_y)
    );

endmodule

// File: rtl/bbox_state.sv
module bbox_state #(
    parameter int XW = 10,
    parameter int YW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [XW-1:0] d_pos_x,
    input  logic [YW-1:0] d_pos_y,
    input  logic [XW-1:0] d_vel_x,
    input  logic [YW-1:0] d_vel_y,
    output logic [XW-1:0] q_pos_x,
    output logic [YW-1:0] q_pos_y,
    output logic [XW-1:0] q_vel_x,
    output logic [YW-1:0] q_vel_y
);

    typedef struct packed {
        logic [XW-1:0] px;
        logic [YW-1:0] py;
        logic [XW-1:0] vx;
        logic [YW-1:0] vy;
    } st_t;

    localparam st_t START = '{px: '0, py: '0, vx: XW'(1), vy: YW'(1)};

    st_t cur;

    always_ff @(posedge clk) begin
        if (rst)
            cur <= START;
        else if (load)
            cur <= '{px: d_pos_x, py: d_pos_y, vx: d_vel_x, vy: d_vel_y};
    end

    assign q_pos_x = cur.px;
    assign q_pos_y = cur.py;
    assign q_vel_x = cur.vx;
    assign q_vel_y = cur.vy;

endmodule

// File: rtl/bbox_mover.sv
module bbox_mover #(
    parameter int SCR_W = bbox_pkg::SCREEN_W,
    parameter int SCR_H = bbox_pkg::SCREEN_H,
    parameter int BOX   = bbox_pkg::BOX_SIDE,
    localparam int XW   = $clog2(SCR_W),
    localparam int YW   = $clog2(SCR_H),
    localparam int XHI  = SCR_W - BOX,
    localparam int YHI  = SCR_H - BOX
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_tick,
    input  logic          halt,
    output logic [XW-1:0] pos_x,
    output logic [YW-1:0] pos_y,
    output logic [XW-1:0] vel_x,
    output logic [YW-1:0] vel_y,
    output logic [XW-1:0] nxt_pos_x,
    output logic [YW-1:0] nxt_pos_y,
    output logic [XW-1:0] nxt_vel_x,
    output logic [YW-1:0] nxt_vel_y
);

    bbox_next #(.XW(XW), .YW(YW), .XHI(XHI), .YHI(YHI)) u_next (
        .halt      (halt),
        .pos_x     (pos_x),
        .pos_y     (pos_y),
        .vel_x     (vel_x),
        .vel_y     (vel_y),
        .nxt_pos_x (nxt_pos_x),
        .nxt_pos_y (nxt_pos_y),
        .nxt_vel_x (nxt_vel_x),
        .nxt_vel_y (nxt_vel_y)
    );

    bbox_state #(.XW(XW), .YW(YW)) u_state (
        .clk     (clk),
        .rst     (rst),
        .load    (frame_tick),
        .d_pos_x (nxt_pos_x),
        .d_pos_y (nxt_pos_y),
        .d_vel_x (nxt_vel_x),
        .d_vel_y (nxt_vel_y),
        .q_pos_x (pos_x),
        .q_pos_y (pos_y),
        .q_vel_x (vel_x),
        .q_vel_y (vel_y)
    );

endmodule

// File: rtl/bbox_chk.sv
module bbox_chk #(
    parameter int XW  = 10,
    parameter int YW  = 9,
    parameter int XHI = 608,
    parameter int YHI = 448
) (
    input logic          clk,
    input logic          rst,
    input logic          frame_tick,
    input logic          halt,
    input logic [XW-1:0] pos_x,
    input logic [YW-1:0] pos_y,
    input logic [XW-1:0] vel_x,
    input logic [YW-1:0] vel_y
);

    localparam logic [XW-1:0] XLIM = XW'(XHI);
    localparam logic [YW-1:0] YLIM = YW'(YHI);
    localparam logic [XW-1:0] X1   = XW'(1);
    localparam logic [YW-1:0] Y1   = YW'(1);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (rst || (pos_x == '0 && pos_y == '0 && vel_x == X1 && vel_y == Y1)));

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
        !frame_tick |=> ($stable(pos_x) && $stable(pos_y) && $stable(vel_x) && $stable(vel_y)));

    assert_step_up_x_R3: assert property (@(posedge clk) disable iff (rst)
        (frame_tick && !halt && !vel_x[XW-1] && pos_x < XLIM)
        |=> (pos_x == $past(pos_x) + X1));

    assert_turn_hi_x_R4: assert property (@(posedge clk) disable iff (rst)
        (frame_tick && !halt && pos_x == XLIM && vel_x == X1)
        |=> (pos_x == XLIM - X1 && vel_x == '1));

    assert_turn_hi_y_R4: assert property (@(posedge clk) disable iff (rst)
        (frame_tick && !halt && pos_y == YLIM && vel_y == Y1)
        |=> (pos_y == YLIM - Y1 && vel_y == '1));

    assert_turn_lo_x_R5: assert property (@(posedge clk) disable iff (rst)
        (frame_tick && !halt && pos_x == '0 && vel_x == '1)
        |=> (pos_x == X1 && vel_x == X1));

    assert_halt_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        (frame_tick && halt) |=> ($stable(pos_x) && $stable(pos_y) && $stable(vel_x) && $stable(vel_y)));

    assert_in_bounds_R8: assert property (@(posedge clk) disable iff (rst)
        (pos_x <= XLIM && pos_y <= YLIM));

    assert_unit_vel_R9: assert property (@(posedge clk) disable iff (rst)
        ((vel_x == X1 || vel_x == '1) && (vel_y == Y1 || vel_y == '1)));

endmodule

bind bbox_mover bbox_chk #(.XW(XW), .YW(YW), .XHI(XHI), .YHI(YHI)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_tick (frame_tick),
    .halt       (halt),
    .pos_x      (pos_x),
    .pos_y      (pos_y),
    .vel_x      (vel_x),
    .vel_y      (vel_y)
);

// File: tb/tb_bbox_mover.sv
`timescale 1ns/1ps
module tb_bbox_mover;

    localparam int XHI = 608;
    localparam int YHI = 448;
    localparam int NSTEP = 3200;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_tick = 1'b0;
    logic       halt = 1'b0;
    logic [9:0] pos_x, nxt_pos_x, vel_x, nxt_vel_x;
    logic [8:0] pos_y, nxt_pos_y, vel_y, nxt_vel_y;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference trajectory
    int mx, my;
    bit nx, ny;
    int ex, ey;
    bit enx, eny;
    bit saw_hi_x, saw_hi_y, saw_lo_x, saw_lo_y, saw_indep;

    always #5 clk = ~clk;

    bbox_mover dut (
        .clk(clk), .rst(rst), .frame_tick(frame_tick), .halt(halt),
        .pos_x(pos_x), .pos_y(pos_y), .vel_x(vel_x), .vel_y(vel_y),
        .nxt_pos_x(nxt_pos_x), .nxt_pos_y(nxt_pos_y),
        .nxt_vel_x(nxt_vel_x), .nxt_vel_y(nxt_vel_y)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int velx(input bit neg);
        return neg ? 10'h3FF : 10'h001;
    endfunction
    function automatic int vely(input bit neg);
        return neg ? 9'h1FF : 9'h001;
    endfunction

    // One axis of the reference, returns a kind: 0 step, 1 turn high, 2 turn low
    function automatic int ref_axis(input int p, input bit n, input int hi,
                                    output int np, output bit nn);
        if (!n && p >= hi) begin np = hi - 1; nn = 1; return 1; end
        if (n && p == 0)   begin np = 1;      nn = 0; return 2; end
        np = n ? p - 1 : p + 1;
        nn = n;
        return 0;
    endfunction

    task automatic check_state(input string tag);
        chk({tag, " pos_x"}, int'(pos_x), mx);
        chk({tag, " pos_y"}, int'(pos_y), my);
        chk({tag, " vel_x"}, int'(vel_x), velx(nx));
        chk({tag, " vel_y"}, int'(vel_y), vely(ny));
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1; frame_tick = 1'b0; halt = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        mx = 0; my = 0; nx = 0; ny = 0;
        #1;
        check_state("R1 reset");
    endtask

    task automatic step(input bit tk, input bit hl);
        int kx, ky;
        string tg;
        @(negedge clk);
        frame_tick = tk; halt = hl;
        #1;
        if (hl) begin
            ex = mx; ey = my; enx = nx; eny = ny;
            tg = "R7 halt";
        end else begin
            kx = ref_axis(mx, nx, XHI, ex, enx);
            ky = ref_axis(my, ny, YHI, ey, eny);
            if (kx == 1 || ky == 1) tg = "R4 turn high";
            else if (kx == 2 || ky == 2) tg = "R5 turn low";
            else tg = "R3 step";
            if ((kx != 0) != (ky != 0)) begin tg = {tg, " R6 indep"}; if (tk) saw_indep = 1; end
            if (tk && kx == 1) saw_hi_x = 1;
            if (tk && ky == 1) saw_hi_y = 1;
            if (tk && kx == 2) saw_lo_x = 1;
            if (tk && ky == 2) saw_lo_y = 1;
        end
        chk({tg, " nxt_pos_x"}, int'(nxt_pos_x), ex);
        chk({tg, " nxt_pos_y"}, int'(nxt_pos_y), ey);
        chk({tg, " nxt_vel_x"}, int'(nxt_vel_x), velx(enx));
        chk({tg, " nxt_vel_y"}, int'(nxt_vel_y), vely(eny));
        @(posedge clk);
        #1;
        if (tk) begin
            mx = ex; my = ey; nx = enx; ny = eny;
        end else begin
            tg = "R2 no tick";
        end
        check_state(tg);
        chk("R8 x bound", int'(pos_x <= 10'(XHI)), 1);
        chk("R8 y bound", int'(pos_y <= 9'(YHI)), 1);
        chk("R9 vel value", int'((vel_x == 10'h001 || vel_x == 10'h3FF) &&
                                 (vel_y == 9'h001 || vel_y == 9'h1FF)), 1);
    endtask

    initial begin
        do_reset();
        for (int i = 0; i < NSTEP; i++) begin
            bit tk, hl;
            tk = (i % 7) != 3;
            hl = (i % 211) < 4;
            step(tk, hl);
        end
        chk("R4 x upper turn seen", int'(saw_hi_x), 1);
        chk("R4 y upper turn seen", int'(saw_hi_y), 1);
        chk("R5 x lower turn seen", int'(saw_lo_x), 1);
        chk("R5 y lower turn seen", int'(saw_lo_y), 1);
        chk("R6 single-axis turn seen", int'(saw_indep), 1);
        // Reset in mid-flight
        do_reset();
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R3 actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule